// File: doc/BRIEF.md
# Counter-Triggered Clock Glitch Injector

This block produces an output clock that copies a base clock cycle for cycle, except for one cycle in which a short extra pulse is inserted. Two delayed copies of the base clock come in from outside: a strongly delayed copy (`clk_b`) and a lightly delayed copy (`clk_c`). The delay of `clk_c` must be smaller than that of `clk_b`, and both must be under half a base period. A cycle counter on the base clock selects one target cycle. During the high half of that cycle, the output mux switches to `clk_b` for as long as `clk_c` is high. The result is a low notch lasting the difference between the two delays, followed by an early rising edge.

Software writes a target cycle index and pulses an arm input. The counter then numbers the base cycles from zero. A one-cycle trigger marks cycle zero, so that trace capture can be aligned to it. The counter value is visible on an output. After the glitch the block goes idle until it is armed again. Nothing happens while the clock generator does not report lock.

Top module: `glitch_injector`

## Requirements
- R1: After a synchronous reset, `busy` and `trig` are low, `cyc_count` is zero, and `clk_out` follows `clk_base`.
- R2: A write (`cfg_we` high at a base rising edge) stores `cfg_target`. An arm accepted at the same edge as a write uses the newly written value. Writes made while busy do not change the glitch already in progress.
- R3: An arm accepted at an edge, while idle and with `locked` high, raises `busy` and sets `cyc_count` to 0 for the next base cycle (cycle index 0).
- R4: `trig` is high for exactly one base cycle, cycle index 0 of each accepted arm, and is low at all other times.
- R5: While busy, `cyc_count` increases by one on every base rising edge, so it equals the current cycle index.
- R6: The glitch occurs only in cycle index equal to the latched target. It consists of a single extra rising edge on `clk_out` that follows a low notch whose width equals the `clk_b` delay minus the `clk_c` delay.
- R7: Each accepted arm produces exactly one glitch, after which `busy` falls in cycle index target+1.
- R8: An arm given while `locked` is low is ignored. If `locked` is low at a rising edge while busy, the block returns to idle and produces no glitch.
- R9: An arm given while busy is ignored and does not restart the count.
- R10: Outside the glitch window, `clk_out` equals `clk_base`, with no extra edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock; all registers run on its rising edge |
| clk_b | input | 1 | Strongly delayed copy of the base clock, switched in during the glitch |
| clk_c | input | 1 | Lightly delayed copy of the base clock, gates the mux select |
| rst | input | 1 | Synchronous active-high reset |
| locked | input | 1 | High when the delayed clocks are valid |
| cfg_we | input | 1 | Write strobe for the target register |
| cfg_target | input | CNT_W | Target cycle index |
| arm | input | 1 | Start request |
| clk_out | output | 1 | Output clock carrying the glitch |
| trig | output | 1 | One-cycle marker of cycle index 0 |
| busy | output | 1 | High from cycle 0 through the target cycle |
| cyc_count | output | CNT_W | Current cycle index while busy |

## Verification
The bench builds the block with `CNT_W = 6`. This makes the largest target (63) reachable in a few dozen cycles, so both ends of the range, 0 and 63, can be tried alongside mid-range values. The delayed clocks are modelled as 0.5 ns and 1.2 ns copies of a 4 ns base clock. The expected notch is therefore 0.7 ns, which the bench measures on `clk_out`. The lock-loss abort, arms while busy, and a write in the same cycle as an arm are each placed at known cycle indices.

// File: rtl/glitch_pkg.sv
`timescale 1ns/1ps
package glitch_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_COUNT  = 2'd1,
        SEQ_STRIKE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       strike;
        logic       busy;
        logic       trig;
    } seq_flags_t;

    function automatic logic idx_matches(input logic [31:0] idx, input logic [31:0] tgt);
        return idx == tgt;
    endfunction

endpackage

// File: rtl/glitch_target_reg.sv
`timescale 1ns/1ps
module glitch_target_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_target,
    input  logic             load,
    output logic [CNT_W-1:0] tgt_next,
    output logic [CNT_W-1:0] tgt_act
);
    logic [CNT_W-1:0] tgt_q;

    // a write in the arm cycle is forwarded to the latch
    assign tgt_next = cfg_we ? cfg_target : tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q   <= '0;
            tgt_act <= '0;
        end else begin
            if (cfg_we) tgt_q <= cfg_target;
            if (load)   tgt_act <= tgt_next;
        end
    end

    // R2: the latched target moves only when an arm is accepted
    assert_latch_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(tgt_act));

endmodule

// File: rtl/glitch_sequencer.sv
`timescale 1ns/1ps
module glitch_sequencer
    import glitch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             locked,
    input  logic [CNT_W-1:0] tgt_next,
    input  logic [CNT_W-1:0] tgt_act,
    output logic             start,
    output seq_flags_t       flags,
    output logic [CNT_W-1:0] cnt
);
    seq_state_e       st;
    logic             trig_q;
    logic [CNT_W-1:0] cnt_inc;

    assign start   = (st == SEQ_IDLE) && arm && locked;
    assign cnt_inc = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SEQ_IDLE;
            cnt    <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (start) begin
                        cnt    <= '0;
                        trig_q <= 1'b1;
                        st     <= (tgt_next == '0) ? SEQ_STRIKE : SEQ_COUNT;
                    end
                end
                SEQ_COUNT: begin
                    if (!locked) begin
                        st <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt_inc;
                        if (idx_matches(32'(cnt_inc), 32'(tgt_act))) st <= SEQ_STRIKE;
                    end
                end
                SEQ_STRIKE: st <= SEQ_IDLE;
                default:    st <= SEQ_IDLE;
            endcase
        end
    end

    assign flags.strike = (st == SEQ_STRIKE);
    assign flags.busy   = (st != SEQ_IDLE);
    assign flags.trig   = trig_q;

    assert_trig_single_R4: assert property (@(posedge clk) disable iff (rst)
        flags.trig |=> !flags.trig);
    assert_start_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (flags.busy && !$past(flags.busy)) |-> (cnt == '0 && flags.trig));
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (flags.busy && $past(flags.busy)) |-> (cnt == $past(cnt) + 1'b1));
    assert_strike_index_R6: assert property (@(posedge clk) disable iff (rst)
        flags.strike |-> (cnt == tgt_act));
    assert_one_strike_R7: assert property (@(posedge clk) disable iff (rst)
        flags.strike |=> !flags.busy);
    assert_lock_abort_R8: assert property (@(posedge clk) disable iff (rst)
        !locked |=> !flags.strike);
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (flags.busy && arm) |=> !flags.trig);

endmodule

// File: rtl/glitch_clock_gate.sv
`timescale 1ns/1ps
module glitch_clock_gate (
    input  logic clk_base,
    input  logic clk_b,
    input  logic clk_c,
    input  logic strike,
    input  logic locked,
    output logic clk_out
);
    logic sel;

    // half-cycle window: strike cycle, high phase of base, after clk_c rises
    assign sel     = strike & locked & clk_base & clk_c;
    assign clk_out = sel ? clk_b : clk_base;

endmodule

// File: rtl/glitch_injector.sv
`timescale 1ns/1ps
module glitch_injector
    import glitch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_base,
    input  logic             clk_b,
    input  logic             clk_c,
    input  logic             rst,
    input  logic             locked,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_target,
    input  logic             arm,
    output logic             clk_out,
    output logic             trig,
    output logic             busy,
    output logic [CNT_W-1:0] cyc_count
);
    logic             start;
    logic [CNT_W-1:0] tgt_next;
    logic [CNT_W-1:0] tgt_act;
    seq_flags_t       flags;

    glitch_target_reg #(.CNT_W(CNT_W)) u_tgt (
        .clk(clk_base), .rst(rst), .cfg_we(cfg_we), .cfg_target(cfg_target),
        .load(start), .tgt_next(tgt_next), .tgt_act(tgt_act)
    );

    glitch_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk(clk_base), .rst(rst), .arm(arm), .locked(locked),
        .tgt_next(tgt_next), .tgt_act(tgt_act), .start(start),
        .flags(flags), .cnt(cyc_count)
    );

    glitch_clock_gate u_gate (
        .clk_base(clk_base), .clk_b(clk_b), .clk_c(clk_c),
        .strike(flags.strike), .locked(locked), .clk_out(clk_out)
    );

    assign trig = flags.trig;
    assign busy = flags.busy;

    // R10: just before each falling base edge, a quiet output is still high
    assert_out_follows_R10: assert property (@(negedge clk_base) disable iff (rst)
        !flags.strike |-> clk_out);
    assert_idle_quiet_R1: assert property (@(posedge clk_base) disable iff (rst)
        !busy |-> !trig);

endmodule

// File: tb/glitch_injector_bench.sv
`timescale 1ns/1ps
module glitch_injector_bench;
    localparam int W = 6;

    logic clk_base = 1'b0;
    logic clk_b = 1'b0;
    logic clk_c = 1'b0;
    logic rst = 1'b1, locked = 1'b1, cfg_we = 1'b0, arm = 1'b0;
    logic [W-1:0] cfg_target = '0;
    logic clk_out, trig, busy;
    logic [W-1:0] cyc_count;

    always #2 clk_base = ~clk_base;
    always @(clk_base) clk_c <= #0.5 clk_base;
    always @(clk_base) clk_b <= #1.2 clk_base;

    glitch_injector #(.CNT_W(W)) u_glitch_injector (
        .clk_base(clk_base), .clk_b(clk_b), .clk_c(clk_c), .rst(rst),
        .locked(locked), .cfg_we(cfg_we), .cfg_target(cfg_target), .arm(arm),
        .clk_out(clk_out), .trig(trig), .busy(busy), .cyc_count(cyc_count)
    );

    int n_chk = 0, n_fail = 0, n_short = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_busy = 0, m_trig = 0, m_hit = 0;
    int m_idx = 0, m_tgt = 0, m_reg = 0;
    real t_base_rise = 0.0, t_out_fall = 0.0;

    always @(posedge clk_base) begin
        t_base_rise = $realtime;
        if (rst) begin
            m_busy = 0; m_trig = 0; m_hit = 0; m_idx = 0; m_tgt = 0; m_reg = 0;
        end else begin
            m_trig = 0;
            if (m_busy) begin
                if (!locked || m_hit) begin
                    m_busy = 0; m_hit = 0;
                end else begin
                    m_idx++;
                    m_hit = (m_idx == m_tgt);
                end
            end else if (arm && locked) begin
                m_busy = 1; m_trig = 1; m_idx = 0;
                m_tgt = cfg_we ? int'(cfg_target) : m_reg;
                m_hit = (m_tgt == 0);
            end
            if (cfg_we) m_reg = int'(cfg_target);
        end
    end

    always @(negedge clk_base) begin
        if (!rst) begin
            check(busy == m_busy, "R3/R7/R8/R9 busy", busy, m_busy);
            check(trig == m_trig, "R4 trig", trig, m_trig);
            if (m_busy) check(int'(cyc_count) == m_idx, "R5 cyc_count", cyc_count, m_idx);
        end
    end

    // glitch monitor: an output rise not aligned with a base rise
    always @(negedge clk_out) t_out_fall = $realtime;
    always @(posedge clk_out) begin
        if ($realtime - t_base_rise > 0.05) begin
            n_short++;
            check(m_hit, "R10 extra edge outside strike cycle", 0, 1);
            check(m_idx == m_tgt, "R6 glitch cycle index", m_idx, m_tgt);
            check(($realtime - t_out_fall) > 0.6 && ($realtime - t_out_fall) < 0.8,
                  "R6 notch width ps", longint'(($realtime - t_out_fall) * 1000.0), 700);
        end
    end

    task automatic write_tgt(input int v);
        @(negedge clk_base); cfg_we = 1; cfg_target = W'(v);
        @(negedge clk_base); cfg_we = 0;
    endtask

    task automatic pulse_arm;
        @(negedge clk_base); arm = 1;
        @(negedge clk_base); arm = 0;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 200 && busy; i++) @(negedge clk_base);
        repeat (2) @(negedge clk_base);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_base);
        check(!busy && !trig && cyc_count == 0, "R1 reset state", {busy, trig}, 0);
        rst = 0;
        repeat (3) @(negedge clk_base);
        check(n_short == 0, "R1 no glitch at rest", n_short, 0);

        // mid-range target
        write_tgt(5); pulse_arm; wait_idle;
        check(n_short == 1, "R7 one glitch target 5", n_short, 1);

        // lowest target
        write_tgt(0); pulse_arm; wait_idle;
        check(n_short == 2, "R7 one glitch target 0", n_short, 2);

        // largest target
        write_tgt(63); pulse_arm; wait_idle;
        check(n_short == 3, "R7 one glitch target 63", n_short, 3);

        // write and arm together: new value forwarded
        @(negedge clk_base); cfg_we = 1; cfg_target = W'(3); arm = 1;
        @(negedge clk_base); cfg_we = 0; arm = 0;
        wait_idle;
        check(n_short == 4, "R2 same-cycle write target 3", n_short, 4);

        // write and re-arm while busy: both ignored for the running glitch
        write_tgt(10); pulse_arm;
        repeat (3) @(negedge clk_base);
        cfg_we = 1; cfg_target = W'(2); arm = 1;
        @(negedge clk_base); cfg_we = 0; arm = 0;
        wait_idle;
        check(n_short == 5, "R9 single glitch despite re-arm", n_short, 5);

        // arm while not locked: ignored (target register now holds 2)
        @(negedge clk_base); locked = 0; arm = 1;
        @(negedge clk_base); arm = 0;
        repeat (6) @(negedge clk_base);
        check(!busy && n_short == 5, "R8 arm without lock ignored", n_short, 5);
        locked = 1;

        // lock lost mid-count: abort
        write_tgt(20); pulse_arm;
        repeat (5) @(negedge clk_base);
        locked = 0;
        @(negedge clk_base); locked = 1;
        @(negedge clk_base);
        check(!busy, "R8 abort on lock loss", busy, 0);
        repeat (25) @(negedge clk_base);
        check(n_short == 5, "R8 no glitch after abort", n_short, 5);

        // re-arm after the abort works again with the stored target
        pulse_arm; wait_idle;
        check(n_short == 6, "R7 re-arm after abort", n_short, 6);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule